// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one timer channel built around a 16-bit counter and four general registers. Each general register is set up on its own, either as an output-compare register that watches the counter or as an input-capture register that stores the counter value when its external input has an edge. Each register owns one compare output pin, which a match can drive low, drive high or toggle. It also owns one capture input pin, which passes through a two-flop synchronizer before edge detection.

The counter moves only on cycles where the clock-enable tick chosen by a 3-bit select is high. In normal mode it counts up. In up/down mode software picks the direction with a control bit. A match or a capture on one chosen register can force the counter back to zero. Events raise sticky flags, and so do a wrap past 0xFFFF upward or past 0x0000 downward. Software clears a flag with a read-then-write-zero sequence.

All registers are reached over a plain 16-bit register bus with no handshake. A write takes effect at the clock edge where `bus_en` and `bus_we` are high. Read data is combinational from `bus_addr`. Word addresses: 0 control, 1 counter, 2 flags, 4..7 general registers A..D, 8..11 channel configuration A..D.

Top module: `cct_timer`

## Requirements
- R1: After reset the counter reads 0x0000, every general register reads 0xFFFF, every channel configuration reads 0 (compare mode, no output action), the flags read 0 and every compare output is 0.
- R2: The counter changes by one only at clock edges where `tick_in[sel]` is high, with sel taken from control bits [2:0]. Ticks on other lines have no effect. With control bit 3 clear the counter only counts up.
- R3: With control bit 3 (up/down) set and control bit 4 (down) set, each tick decrements the counter. A tick at 0x0000 wraps it to 0xFFFF and sets the underflow flag (flags bit 5).
- R4: An upward tick at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (flags bit 4).
- R5: When a register is in compare mode (configuration bit 0 = 0) and a tick arrives while the counter equals that register, its event flag (flags bit i for register i) is set.
- R6: On such a match the register's compare output follows configuration bits [4:3]: 00 unchanged, 01 driven 0, 10 driven 1, 11 toggled.
- R7: With control bit 5 (clear enable) set and control bits [7:6] naming register i, a match on register i loads 0x0000 into the counter instead of advancing it.
- R8: In capture mode (configuration bit 0 = 1) the counter value is latched into the register and its event flag is set on the synchronized input edge picked by configuration bits [2:1]: 00 none, 01 rising, 10 falling, 11 both. The capture happens at the third clock edge after the pin changes.
- R9: A capture into the register named by control bits [7:6] with clear enable set loads 0x0000 into the counter at the capture edge.
- R10: A write to the counter or to a general register with `bus_be` other than 2'b11 is ignored.
- R11: Flags are sticky. Writing 0 to a flag bit clears it only if that bit read as 1 since the last flags write. A hardware set in the same cycle as the clear wins.
- R12: A bus write to the counter takes priority over clearing and counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 8 | Clock-enable tick lines, one picked by the select field |
| cap_in | input | 4 | Capture input pins, one per general register |
| cmp_out | output | 4 | Compare output pins, one per general register |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | 4 | Bus word address |
| bus_be | input | 2 | Byte enables; counter and general registers need 2'b11 |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data for the current address |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, four general registers and eight tick lines. Because the counter can be written directly, both wrap boundaries and every match value are reached in a handful of ticks, with no need to count through the full 16-bit range. With eight tick lines, the test can drive an unselected line and show it is ignored. With four registers, one register can act as clear source and capture source while others keep their reset value of 0xFFFF and match at the overflow point.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    CAP_NONE = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_ANY  = 2'b11
  } cap_sel_e;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_LOW    = 2'b01,
    PIN_HIGH   = 2'b10,
    PIN_TOGGLE = 2'b11
  } pin_act_e;

  // bit 0 capture mode, bits [2:1] capture edge, bits [4:3] pin action
  typedef struct packed {
    pin_act_e act;
    cap_sel_e cap_sel;
    logic     capture;
  } chan_cfg_t;

  localparam int CFG_W       = 5;
  localparam int ADDR_W      = 4;
  localparam int A_CTRL      = 0;
  localparam int A_COUNT     = 1;
  localparam int A_FLAGS     = 2;
  localparam int A_GR_BASE   = 4;
  localparam int A_CFG_BASE  = 8;

endpackage

// File: rtl/cct_tick_sel.sv
module cct_tick_sel #(
  parameter int NTICK = 8,
  localparam int SEL_W = $clog2(NTICK)
) (
  input  logic [NTICK-1:0] tick_in,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NTICK; i++) begin
      if (sel == SEL_W'(i)) tick = tick_in[i];
    end
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clear,
  input  logic         tick,
  input  logic         down,
  output logic [W-1:0] count,
  output logic         ovf_set,
  output logic         udf_set
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    ovf_set = 1'b0;
    udf_set = 1'b0;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      if (down) begin
        cnt_d   = cnt_q - 1'b1;
        udf_set = (cnt_q == '0);
      end else begin
        cnt_d   = cnt_q + 1'b1;
        ovf_set = (cnt_q == '1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> (count == '0)); // R4
  AST_UDF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    udf_set |=> (count == '1)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data))); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clear && !tick) |=> $stable(count)); // R2
endmodule

// File: rtl/cct_chan.sv
module cct_chan
  import cct_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  chan_cfg_t    cfg,
  input  logic [W-1:0] count,
  input  logic         tick,
  input  logic         cap_pin,
  input  logic         gr_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] gr,
  output logic         evt,
  output logic         pin
);
  logic [SYNC-1:0] sync_q;
  logic            last_q;
  logic            rise, fall, hit;
  logic            cap_evt, cmp_evt;
  logic [W-1:0]    gr_q;
  logic            pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], cap_pin};
      last_q <= sync_q[SYNC-1];
    end
  end

  assign rise = sync_q[SYNC-1] & ~last_q;
  assign fall = ~sync_q[SYNC-1] & last_q;

  always_comb begin
    case (cfg.cap_sel)
      CAP_RISE: hit = rise;
      CAP_FALL: hit = fall;
      CAP_ANY:  hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

  assign cap_evt = cfg.capture & hit;
  assign cmp_evt = ~cfg.capture & tick & (count == gr_q);
  assign evt     = cap_evt | cmp_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)       gr_q <= '1;
    else if (cap_evt) gr_q <= count;
    else if (gr_wr)   gr_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (cmp_evt) begin
      case (cfg.act)
        PIN_LOW:    pin_q <= 1'b0;
        PIN_HIGH:   pin_q <= 1'b1;
        PIN_TOGGLE: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign gr  = gr_q;
  assign pin = pin_q;

  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (gr == $past(count))); // R8
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_evt |=> $stable(pin)); // R6
  AST_CAP_MODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gr_wr && !cap_evt) |=> $stable(gr)); // R10
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NREG  = 4,
  parameter int NTICK = 8,
  parameter int SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTICK-1:0]  tick_in,
  input  logic [NREG-1:0]   cap_in,
  output logic [NREG-1:0]   cmp_out,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W/8-1:0] bus_be,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata
);
  localparam int SEL_W  = $clog2(NTICK);
  localparam int IDX_W  = $clog2(NREG);
  localparam int CTRL_W = SEL_W + 3 + IDX_W;
  localparam int FLG_W  = NREG + 2;
  localparam int B_UD   = SEL_W;
  localparam int B_DN   = SEL_W + 1;
  localparam int B_CLR  = SEL_W + 2;
  localparam int B_SRC  = SEL_W + 3;

  logic [CTRL_W-1:0] ctrl_q;
  logic [FLG_W-1:0]  flags_q, armed_q, hw_set, clr_mask;
  chan_cfg_t         cfg_q [NREG];
  logic [CNT_W-1:0]  gr_all [NREG];
  logic [NREG-1:0]   evt;
  logic [CNT_W-1:0]  count;
  logic              tick, ovf_set, udf_set, clr_hit, cnt_wr;
  logic              wr, rd, full, wr_flags, rd_flags;

  assign wr       = bus_en & bus_we;
  assign rd       = bus_en & ~bus_we;
  assign full     = &bus_be;
  assign wr_flags = wr & (bus_addr == ADDR_W'(A_FLAGS));
  assign rd_flags = rd & (bus_addr == ADDR_W'(A_FLAGS));
  assign cnt_wr   = wr & full & (bus_addr == ADDR_W'(A_COUNT));

  always_ff @(posedge clk) begin
    if (!rst_n)                                    ctrl_q <= '0;
    else if (wr && bus_addr == ADDR_W'(A_CTRL))    ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  cct_tick_sel #(.NTICK(NTICK)) u_tick (
    .tick_in (tick_in),
    .sel     (ctrl_q[SEL_W-1:0]),
    .tick    (tick)
  );

  assign clr_hit = ctrl_q[B_CLR] & evt[ctrl_q[B_SRC +: IDX_W]];

  cct_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_wr),
    .wr_data (bus_wdata),
    .clear   (clr_hit),
    .tick    (tick),
    .down    (ctrl_q[B_UD] & ctrl_q[B_DN]),
    .count   (count),
    .ovf_set (ovf_set),
    .udf_set (udf_set)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_ch
    logic cfg_wr, gr_wr;
    assign cfg_wr = wr & (bus_addr == ADDR_W'(A_CFG_BASE + g));
    assign gr_wr  = wr & full & (bus_addr == ADDR_W'(A_GR_BASE + g));

    always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q[g] <= '0;
      else if (cfg_wr) cfg_q[g] <= chan_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    cct_chan #(.W(CNT_W), .SYNC(SYNC)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg_q[g]),
      .count   (count),
      .tick    (tick),
      .cap_pin (cap_in[g]),
      .gr_wr   (gr_wr),
      .wr_data (bus_wdata),
      .gr      (gr_all[g]),
      .evt     (evt[g]),
      .pin     (cmp_out[g])
    );
  end

  assign hw_set   = {udf_set, ovf_set, evt};
  assign clr_mask = wr_flags ? (armed_q & ~bus_wdata[FLG_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      armed_q <= '0;
    end else begin
      flags_q <= hw_set | (flags_q & ~clr_mask);
      if (wr_flags)      armed_q <= '0;
      else if (rd_flags) armed_q <= armed_q | flags_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL))  bus_rdata = CNT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(A_COUNT)) bus_rdata = count;
    if (bus_addr == ADDR_W'(A_FLAGS)) bus_rdata = CNT_W'(flags_q);
    for (int i = 0; i < NREG; i++) begin
      if (bus_addr == ADDR_W'(A_GR_BASE + i))  bus_rdata = gr_all[i];
      if (bus_addr == ADDR_W'(A_CFG_BASE + i)) bus_rdata = CNT_W'(cfg_q[i]);
    end
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flags_q & $past(hw_set)) == $past(hw_set))); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R11
  AST_CLEAR_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !cnt_wr) |=> (count == '0)); // R7
endmodule

// File: tb/cct_timer_bench.sv
`timescale 1ns/100ps
module cct_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tick_in = '0;
  logic [3:0]  cap_in = '0;
  logic [3:0]  cmp_out;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cct_timer u_cct_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cap_in(cap_in),
    .cmp_out(cmp_out), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  localparam logic [3:0] CTRL = 4'd0, CNT = 4'd1, FLG = 4'd2;
  localparam logic [3:0] GRA = 4'd4, GRB = 4'd5, GRC = 4'd6, GRD = 4'd7;
  localparam logic [3:0] CFA = 4'd8, CFC = 4'd10, CFD = 4'd11;

  // op: 0 write, 1 read and compare, 2 tick (all lines) data times
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [1:0]  be;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{2'd1, CNT,  2'b11, 16'h0000, 16'h0000, 4'd1},  // R1 counter
    '{2'd1, GRA,  2'b11, 16'h0000, 16'hFFFF, 4'd1},  // R1 GR A
    '{2'd1, GRD,  2'b11, 16'h0000, 16'hFFFF, 4'd1},  // R1 GR D
    '{2'd1, CFA,  2'b11, 16'h0000, 16'h0000, 4'd1},  // R1 config
    '{2'd1, FLG,  2'b11, 16'h0000, 16'h0000, 4'd1},  // R1 flags
    '{2'd0, CNT,  2'b11, 16'h0010, 16'h0000, 4'd2},
    '{2'd2, CNT,  2'b11, 16'd5,    16'h0000, 4'd2},
    '{2'd1, CNT,  2'b11, 16'h0000, 16'h0015, 4'd2},  // R2
    '{2'd0, CNT,  2'b11, 16'hFFFE, 16'h0000, 4'd4},
    '{2'd2, CNT,  2'b11, 16'd2,    16'h0000, 4'd4},
    '{2'd1, CNT,  2'b11, 16'h0000, 16'h0000, 4'd4},  // R4 wrap
    '{2'd1, FLG,  2'b11, 16'h0000, 16'h001F, 4'd4},  // R4 ovf + matches at FFFF
    '{2'd0, FLG,  2'b11, 16'h0000, 16'h0000, 4'd11},
    '{2'd1, FLG,  2'b11, 16'h0000, 16'h0000, 4'd11}, // R11 read-then-clear
    '{2'd0, CTRL, 2'b11, 16'h0018, 16'h0000, 4'd3},
    '{2'd0, CNT,  2'b11, 16'h0001, 16'h0000, 4'd3},
    '{2'd2, CNT,  2'b11, 16'd2,    16'h0000, 4'd3},
    '{2'd1, CNT,  2'b11, 16'h0000, 16'hFFFF, 4'd3},  // R3 down wrap
    '{2'd1, FLG,  2'b11, 16'h0000, 16'h0020, 4'd3},  // R3 udf
    '{2'd0, FLG,  2'b11, 16'h0000, 16'h0000, 4'd11},
    '{2'd0, CTRL, 2'b11, 16'h0000, 16'h0000, 4'd5},
    '{2'd0, GRB,  2'b11, 16'h0103, 16'h0000, 4'd5},
    '{2'd0, CNT,  2'b11, 16'h0100, 16'h0000, 4'd5},
    '{2'd2, CNT,  2'b11, 16'd4,    16'h0000, 4'd5},
    '{2'd1, FLG,  2'b11, 16'h0000, 16'h0002, 4'd5},  // R5 match B
    '{2'd0, CNT,  2'b01, 16'h1234, 16'h0000, 4'd10},
    '{2'd1, CNT,  2'b11, 16'h0000, 16'h0104, 4'd10}, // R10 counter byte write
    '{2'd0, GRB,  2'b10, 16'hAAAA, 16'h0000, 4'd10},
    '{2'd1, GRB,  2'b11, 16'h0000, 16'h0103, 4'd10}, // R10 GR byte write
    '{2'd0, FLG,  2'b11, 16'h0000, 16'h0000, 4'd11}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic ticks(input logic [7:0] mask, input int n);
    @(negedge clk);
    tick_in = mask;
    repeat (n) @(negedge clk);
    tick_in = '0;
  endtask

  task automatic pin_set(input int idx, input logic v);
    @(negedge clk);
    cap_in[idx] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 compare outputs", {12'h0, cmp_out}, 16'h0000);

    foreach (VECS[k]) begin
      case (VECS[k].op)
        2'd0: bwr(VECS[k].addr, VECS[k].data, VECS[k].be);
        2'd1: begin
          brd(VECS[k].addr, r);
          chk($sformatf("R%0d vector %0d", VECS[k].req, k), r, VECS[k].exp);
        end
        default: ticks(8'hFF, int'(VECS[k].data));
      endcase
    end

    // R7: clear on match with register B
    bwr(CTRL, 16'h0060);
    bwr(CNT, 16'h0102);
    ticks(8'hFF, 2);
    brd(CNT, r); chk("R7 cleared on match", r, 16'h0000);
    ticks(8'hFF, 3);
    brd(CNT, r); chk("R7 counts after clear", r, 16'h0003);

    // R2: only the selected tick line advances the counter
    bwr(CTRL, 16'h0003);
    bwr(CNT, 16'h0000);
    ticks(8'b0000_0100, 4);
    brd(CNT, r); chk("R2 unselected tick ignored", r, 16'h0000);
    ticks(8'b0000_1000, 2);
    brd(CNT, r); chk("R2 selected tick", r, 16'h0002);

    // R6: pin actions on register C
    bwr(CTRL, 16'h0000);
    bwr(GRC, 16'h0050);
    bwr(CFC, 16'h0018);
    bwr(CNT, 16'h0050); ticks(8'hFF, 1);
    chk("R6 toggle high", {15'h0, cmp_out[2]}, 16'h0001);
    bwr(CNT, 16'h0050); ticks(8'hFF, 1);
    chk("R6 toggle low", {15'h0, cmp_out[2]}, 16'h0000);
    bwr(CFC, 16'h0010);
    bwr(CNT, 16'h0050); ticks(8'hFF, 1);
    chk("R6 set high", {15'h0, cmp_out[2]}, 16'h0001);
    bwr(CFC, 16'h0000);
    bwr(CNT, 16'h0050); ticks(8'hFF, 1);
    chk("R6 keep", {15'h0, cmp_out[2]}, 16'h0001);
    bwr(CFC, 16'h0008);
    bwr(CNT, 16'h0050); ticks(8'hFF, 1);
    chk("R6 drive low", {15'h0, cmp_out[2]}, 16'h0000);

    // R8: capture edges on register D
    bwr(FLG, 16'h0000);
    brd(FLG, r); bwr(FLG, 16'h0000);
    bwr(CFD, 16'h0003);
    bwr(CNT, 16'h0777);
    pin_set(3, 1'b1);
    brd(GRD, r); chk("R8 rising capture", r, 16'h0777);
    brd(FLG, r); chk("R8 capture flag", r & 16'h0008, 16'h0008);
    bwr(CNT, 16'h0888);
    pin_set(3, 1'b0);
    brd(GRD, r); chk("R8 falling ignored when rising only", r, 16'h0777);
    bwr(CFD, 16'h0007);
    bwr(CNT, 16'h0999);
    pin_set(3, 1'b1);
    brd(GRD, r); chk("R8 both edges", r, 16'h0999);
    bwr(CFD, 16'h0005);
    bwr(CNT, 16'h0AAA);
    pin_set(3, 1'b0);
    brd(GRD, r); chk("R8 falling capture", r, 16'h0AAA);
    bwr(CFD, 16'h0001);
    bwr(CNT, 16'h0BBB);
    pin_set(3, 1'b1);
    brd(GRD, r); chk("R8 capture disabled", r, 16'h0AAA);

    // R9: capture on register D clears the counter
    pin_set(3, 1'b0);
    bwr(CFD, 16'h0003);
    bwr(CTRL, 16'h00E0);
    bwr(CNT, 16'h0CCC);
    pin_set(3, 1'b1);
    brd(GRD, r); chk("R9 captured value", r, 16'h0CCC);
    brd(CNT, r); chk("R9 counter cleared", r, 16'h0000);

    // R11: hardware set beats clear in same cycle; clear needs prior read
    bwr(CTRL, 16'h0000);
    bwr(GRB, 16'h0200);
    bwr(CNT, 16'h0200);
    brd(FLG, r);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = FLG; bus_wdata = 16'h0000; bus_be = 2'b11;
    tick_in = 8'hFF;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; tick_in = '0;
    brd(FLG, r); chk("R11 set wins over clear", r & 16'h0002, 16'h0002);
    bwr(FLG, 16'h0000);
    bwr(FLG, 16'h0000);
    brd(FLG, r); chk("R11 cleared after read", r & 16'h0002, 16'h0000);
    bwr(CNT, 16'h0200); ticks(8'hFF, 1);
    bwr(FLG, 16'h0000);
    brd(FLG, r); chk("R11 unread flag kept", r & 16'h0002, 16'h0002);

    // R12: counter write beats tick and clear
    bwr(CTRL, 16'h0060);
    bwr(GRB, 16'h0005);
    bwr(CNT, 16'h0005);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = CNT; bus_wdata = 16'h0040; bus_be = 2'b11;
    tick_in = 8'hFF;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; tick_in = '0;
    brd(CNT, r); chk("R12 write over tick and clear", r, 16'h0040);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule